// File: doc/BRIEF.md
# Real-Time-Clock Status and Event-Flag Register Bank

This block holds the status and event-flag registers of a real-time-clock controller. A host reaches it over a plain parallel bus made of an address, a write data byte, a read strobe and a write strobe. Read data comes back registered. The bank has two registers. The first is a main status register that decodes at address 0 in every register block and on every page. The second is a periodic flag register that decodes only in block 0 of the register page.

The main status register does several jobs. It reports the interrupt pin levels and latches three interrupt events. It also holds two spare storage bits and the block and page select bits that the rest of the controller uses to steer its address map. The periodic flag register collects the timekeeping rollover pulses and the oscillator-fail flag. When written, it drives the single-supply mode bit and the enable for the test register.

Each flag has its own clearing rule:
- Some flags clear when a one is written to them.
- One flag clears when the power-fail pin reports good power.
- The rollover flags clear when their register is read.
- The oscillator-fail flag clears only through a start command taken from another register.

Top module: `rtc_flag_regs`

## Requirements
- R1: After reset, the main status bits 1 to 7 and the periodic rollover flags are 0. The oscillator-fail flag reads 1, `singleSupply` is 1, `testRegEn` is 0, and `rdData` is 0.
- R2: Address 0 always selects the main status register, whatever the values of `blockSel` and `pageSel`. A write there loads bits 4 and 5 as storage, bit 6 into `blockSel` and bit 7 into `pageSel`.
- R3: Main status bit 0 reads as `intPinLvl | (mfoPinLvl & mfoIsIntr)`. Writes have no effect on it.
- R4: Main status bit 2 is set by `tmrEvt` and bit 3 by `almEvt`, with no mask applied. Both hold their state through reads. A write to address 0 clears only the bits among 2 and 3 that are written as 1.
- R5: Main status bit 1 is set by `pfailEvt`. Writes do not change it. It clears in a cycle where `powerGood` is 1 and no `pfailEvt` arrives.
- R6: The periodic flag register sits at address `PF_ADDR` (default 3) and decodes only when `blockSel` and `pageSel` are both 0. Its bits 0 to 5 are set by `rollEvt[5:0]` one for one. A read returns their values and then clears all six.
- R7: An event that arrives in the same cycle as the read or write-one that would clear its flag leaves that flag set.
- R8: Periodic flag bit 6 reads the oscillator-fail flag. The flag is set by reset and by `oscFailEvt`. It clears only on `clkStartWr` while `oscRunning` is 1.
- R9: A write to the periodic flag register loads bit 6 into `singleSupply` and bit 7 into `testRegEn`. `oscFailEvt` forces `singleSupply` to 1. Bit 7 reads back `testRegEn`.
- R10: `rdData` updates on the clock edge that samples `rdStrobe`. Reading any address that decodes to neither register returns 0, and such a read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| rdStrobe | input | 1 | Read strobe, one cycle |
| wrStrobe | input | 1 | Write strobe, one cycle |
| rdData | output | 8 | Registered read data |
| intPinLvl | input | 1 | Interrupt pin pending level |
| mfoPinLvl | input | 1 | Multifunction pin pending level |
| mfoIsIntr | input | 1 | Multifunction pin configured as an interrupt |
| pfailEvt | input | 1 | Power-fail interrupt event |
| powerGood | input | 1 | Power-fail pin reports good power |
| tmrEvt | input | 1 | Timer interrupt event |
| almEvt | input | 1 | Alarm interrupt event |
| rollEvt | input | 6 | Timekeeping rollover pulses |
| oscFailEvt | input | 1 | Oscillator-fail event |
| oscRunning | input | 1 | Oscillator currently running |
| clkStartWr | input | 1 | Write of 1 to the clock start bit in the mode register |
| blockSel | output | 1 | Register block select |
| pageSel | output | 1 | Register or RAM page select |
| singleSupply | output | 1 | Single-supply mode |
| testRegEn | output | 1 | Test register enable |

## Verification
Two functions can land in the same cycle: a flag-setting event and the bus access that clears that flag. For the rollover flags, this is a rollover pulse that arrives in the same cycle as a read of the periodic flag register. For the timer bit, this is a `tmrEvt` pulse that arrives alongside a write of 1 to bit 2. The bench raises the strobe and the event on the same falling edge, so the rising edge that follows samples both. It then judges the outcome in two steps. The colliding read must return the flag's old value. A second read must show that the flag is still set.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  typedef struct packed {
    logic msSel;
    logic pfSel;
    logic msWrite;
    logic pfWrite;
    logic pfRead;
    logic anyRead;
  } ctrlStrobes_t;
endpackage

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
  import rtc_flag_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int PF_ADDR = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              blockSel,
  input  logic              pageSel,
  output ctrlStrobes_t      stb
);
  localparam logic [ADDR_W-1:0] MS_A = '0;
  localparam logic [ADDR_W-1:0] PF_A = ADDR_W'(PF_ADDR);

  logic msHit, pfHit;

  // main status ignores bank and page; periodic flags only in block 0 of the register page
  assign msHit = (addr == MS_A);
  assign pfHit = (addr == PF_A) && !blockSel && !pageSel;

  always_comb begin
    stb.msSel   = msHit;
    stb.pfSel   = pfHit;
    stb.msWrite = wrStrobe && msHit;
    stb.pfWrite = wrStrobe && pfHit;
    stb.pfRead  = rdStrobe && pfHit;
    stb.anyRead = rdStrobe;
  end
endmodule

// File: rtl/rtc_flag_dp.sv
module rtc_flag_dp
  import rtc_flag_pkg::*;
#(
  parameter int ROLL_N = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [7:0]        wrData,
  input  logic              intPinLvl,
  input  logic              mfoPinLvl,
  input  logic              mfoIsIntr,
  input  logic              pfailEvt,
  input  logic              powerGood,
  input  logic              tmrEvt,
  input  logic              almEvt,
  input  logic [ROLL_N-1:0] rollEvt,
  input  logic              oscFailEvt,
  input  logic              oscRunning,
  input  logic              clkStartWr,
  output logic [7:0]        rdData,
  output logic              blockSel,
  output logic              pageSel,
  output logic              singleSupply,
  output logic              testRegEn
);
  localparam int PAD_W = 6 - ROLL_N;

  logic              msPfail, msTmr, msAlm;
  logic [1:0]        msSpare;
  logic [ROLL_N-1:0] pfFlags;
  logic              oscFail;
  logic [7:0]        msByte, pfByte, rdNext;
  logic              pendLvl;

  assign pendLvl = intPinLvl | (mfoPinLvl & mfoIsIntr);
  assign msByte  = {pageSel, blockSel, msSpare, msAlm, msTmr, msPfail, pendLvl};

  generate
    if (PAD_W > 0) begin : g_pad
      assign pfByte = {testRegEn, oscFail, {PAD_W{1'b0}}, pfFlags};
    end else begin : g_full
      assign pfByte = {testRegEn, oscFail, pfFlags};
    end
  endgenerate

  always_comb begin
    if (stb.msSel)      rdNext = msByte;
    else if (stb.pfSel) rdNext = pfByte;
    else                rdNext = 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msPfail      <= 1'b0;
      msTmr        <= 1'b0;
      msAlm        <= 1'b0;
      msSpare      <= 2'b00;
      blockSel     <= 1'b0;
      pageSel      <= 1'b0;
      pfFlags      <= '0;
      oscFail      <= 1'b1;
      singleSupply <= 1'b1;
      testRegEn    <= 1'b0;
      rdData       <= 8'h00;
    end else begin
      // set wins over every clear
      msPfail <= pfailEvt | (msPfail & !powerGood);
      msTmr   <= tmrEvt | (msTmr & !(stb.msWrite & wrData[2]));
      msAlm   <= almEvt | (msAlm & !(stb.msWrite & wrData[3]));
      if (stb.msWrite) begin
        msSpare  <= wrData[5:4];
        blockSel <= wrData[6];
        pageSel  <= wrData[7];
      end
      pfFlags <= rollEvt | (pfFlags & {ROLL_N{!stb.pfRead}});
      oscFail <= oscFailEvt | (oscFail & !(clkStartWr & oscRunning));
      if (oscFailEvt)       singleSupply <= 1'b1;
      else if (stb.pfWrite) singleSupply <= wrData[6];
      if (stb.pfWrite)      testRegEn <= wrData[7];
      if (stb.anyRead)      rdData <= rdNext;
    end
  end

  // R7: a timer event colliding with a write-one clear leaves the bit set
  assert_tmr_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    tmrEvt |=> msTmr);

  // R6 / R7: every rollover pulse is captured, read or not
  assert_roll_captured_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|rollEvt) |=> ((pfFlags & $past(rollEvt)) == $past(rollEvt)));

  // R6: a read with no new pulse leaves all rollover flags clear
  assert_roll_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pfRead && !(|rollEvt)) |=> (pfFlags == '0));

  // R5: the power-fail bit survives until power is reported good
  assert_pfail_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (msPfail && !powerGood) |=> msPfail);

  // R8 / R9: an oscillator fail sets the flag and the supply mode
  assert_oscfail_forces_R8: assert property (@(posedge clk) disable iff (!rstN)
    oscFailEvt |=> (oscFail && singleSupply));

  // R8: the flag cannot drop without a start command on a running oscillator
  assert_oscfail_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (oscFail && !(clkStartWr && oscRunning)) |=> oscFail);

  // R2: select bits change only through a write to address 0
  assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.msWrite |=> ($stable(blockSel) && $stable(pageSel)));

  // R10: read data holds when no read is made
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.anyRead |=> $stable(rdData));
endmodule

// File: rtl/rtc_flag_regs.sv
module rtc_flag_regs
  import rtc_flag_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int PF_ADDR = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  output logic [7:0]        rdData,
  input  logic              intPinLvl,
  input  logic              mfoPinLvl,
  input  logic              mfoIsIntr,
  input  logic              pfailEvt,
  input  logic              powerGood,
  input  logic              tmrEvt,
  input  logic              almEvt,
  input  logic [5:0]        rollEvt,
  input  logic              oscFailEvt,
  input  logic              oscRunning,
  input  logic              clkStartWr,
  output logic              blockSel,
  output logic              pageSel,
  output logic              singleSupply,
  output logic              testRegEn
);
  ctrlStrobes_t stb;

  rtc_flag_ctrl #(.ADDR_W(ADDR_W), .PF_ADDR(PF_ADDR)) u_ctrl (
    .addr(addr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .blockSel(blockSel), .pageSel(pageSel), .stb(stb)
  );

  rtc_flag_dp #(.ROLL_N(6)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .intPinLvl(intPinLvl), .mfoPinLvl(mfoPinLvl), .mfoIsIntr(mfoIsIntr),
    .pfailEvt(pfailEvt), .powerGood(powerGood), .tmrEvt(tmrEvt), .almEvt(almEvt),
    .rollEvt(rollEvt), .oscFailEvt(oscFailEvt), .oscRunning(oscRunning),
    .clkStartWr(clkStartWr), .rdData(rdData), .blockSel(blockSel),
    .pageSel(pageSel), .singleSupply(singleSupply), .testRegEn(testRegEn)
  );
endmodule

// File: tb/rtc_flag_regs_test.sv
module rtc_flag_regs_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [7:0] rdData;
  logic       intPinLvl = 1'b0, mfoPinLvl = 1'b0, mfoIsIntr = 1'b0;
  logic       pfailEvt = 1'b0, powerGood = 1'b1, tmrEvt = 1'b0, almEvt = 1'b0;
  logic [5:0] rollEvt = '0;
  logic       oscFailEvt = 1'b0, oscRunning = 1'b0, clkStartWr = 1'b0;
  logic       blockSel, pageSel, singleSupply, testRegEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_flag_regs uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .rdData(rdData), .intPinLvl(intPinLvl), .mfoPinLvl(mfoPinLvl),
    .mfoIsIntr(mfoIsIntr), .pfailEvt(pfailEvt), .powerGood(powerGood), .tmrEvt(tmrEvt),
    .almEvt(almEvt), .rollEvt(rollEvt), .oscFailEvt(oscFailEvt), .oscRunning(oscRunning),
    .clkStartWr(clkStartWr), .blockSel(blockSel), .pageSel(pageSel),
    .singleSupply(singleSupply), .testRegEn(testRegEn)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    d = rdData;
  endtask

  task automatic pulseAt(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 singleSupply", {7'd0, singleSupply}, 8'h01);
    check("R1 testRegEn", {7'd0, testRegEn}, 8'h00);
    check("R1 rdData", rdData, 8'h00);
    doRead(5'd0, d); check("R1 main status", d, 8'h00);
    doRead(5'd3, d); check("R1 periodic flags", d, 8'h40);
  endtask

  task automatic t_addr0();
    logic [7:0] d;
    doWrite(5'd0, 8'hF0);
    check("R2 selects", {6'd0, pageSel, blockSel}, 8'h03);
    doRead(5'd0, d); check("R2 address0 in block1 page1", d, 8'hF0);
    doRead(5'd3, d); check("R6 periodic not decoded off block0", d, 8'h00);
    doWrite(5'd0, 8'h40);
    doRead(5'd0, d); check("R2 address0 in block1", d, 8'h40);
    doWrite(5'd0, 8'h00);
    doRead(5'd3, d); check("R6 periodic decoded in block0 page0", d, 8'h40);
  endtask

  task automatic t_pins();
    logic [7:0] d;
    intPinLvl = 1'b1;
    doRead(5'd0, d); check("R3 int pin", d, 8'h01);
    intPinLvl = 1'b0; mfoPinLvl = 1'b1;
    doRead(5'd0, d); check("R3 mfo not interrupt", d, 8'h00);
    mfoIsIntr = 1'b1;
    doWrite(5'd0, 8'h01);
    doRead(5'd0, d); check("R3 mfo as interrupt", d, 8'h01);
    mfoPinLvl = 1'b0; mfoIsIntr = 1'b0;
    doRead(5'd0, d); check("R3 pins low", d, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    pulseAt(tmrEvt);
    pulseAt(almEvt);
    doRead(5'd0, d); check("R4 both set", d, 8'h0C);
    doRead(5'd0, d); check("R4 hold on read", d, 8'h0C);
    doWrite(5'd0, 8'h04);
    doRead(5'd0, d); check("R4 clear bit2 only", d, 8'h08);
    doWrite(5'd0, 8'h00);
    doRead(5'd0, d); check("R4 write zero keeps", d, 8'h08);
    doWrite(5'd0, 8'h08);
    doRead(5'd0, d); check("R4 clear bit3", d, 8'h00);
  endtask

  task automatic t_pfail();
    logic [7:0] d;
    powerGood = 1'b0;
    pulseAt(pfailEvt);
    doRead(5'd0, d); check("R5 set", d, 8'h02);
    doWrite(5'd0, 8'h02);
    doRead(5'd0, d); check("R5 write ignored", d, 8'h02);
    powerGood = 1'b1;
    @(negedge clk);
    doRead(5'd0, d); check("R5 cleared by pin", d, 8'h00);
  endtask

  task automatic t_roll();
    logic [7:0] d;
    @(negedge clk); rollEvt = 6'b100101;
    @(negedge clk); rollEvt = '0;
    doRead(5'd3, d); check("R6 flags set", d, 8'h65);
    doRead(5'd3, d); check("R6 cleared on read", d, 8'h40);
    @(negedge clk); rollEvt = 6'b000001;
    @(negedge clk); rollEvt = '0;
    doRead(5'd5, d); check("R10 unmapped reads zero", d, 8'h00);
    doRead(5'd3, d); check("R10 unmapped read clears nothing", d, 8'h41);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk);
    addr = 5'd3; rdStrobe = 1'b1; rollEvt = 6'b000010;
    @(negedge clk);
    rdStrobe = 1'b0; rollEvt = '0; d = rdData;
    check("R7 colliding read returns old", d, 8'h40);
    doRead(5'd3, d); check("R7 roll flag kept", d, 8'h42);
    pulseAt(tmrEvt);
    @(negedge clk);
    addr = 5'd0; wrData = 8'h04; wrStrobe = 1'b1; tmrEvt = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; tmrEvt = 1'b0;
    doRead(5'd0, d); check("R7 timer bit kept", d, 8'h04);
    doWrite(5'd0, 8'h04);
    doRead(5'd0, d); check("R4 timer cleared after", d, 8'h00);
  endtask

  task automatic t_osc();
    logic [7:0] d;
    oscRunning = 1'b0;
    pulseAt(clkStartWr);
    doRead(5'd3, d); check("R8 no clear while stopped", d, 8'h40);
    oscRunning = 1'b1;
    pulseAt(clkStartWr);
    doRead(5'd3, d); check("R8 cleared by start", d, 8'h00);
    doWrite(5'd3, 8'h00);
    check("R9 single supply off", {7'd0, singleSupply}, 8'h00);
    doWrite(5'd3, 8'h80);
    check("R9 test enable", {6'd0, testRegEn, singleSupply}, 8'h02);
    pulseAt(oscFailEvt);
    check("R9 osc fail forces supply", {7'd0, singleSupply}, 8'h01);
    doRead(5'd3, d); check("R8 osc fail sets flag", d, 8'hC0);
    doWrite(5'd3, 8'h40);
    check("R9 test off supply on", {6'd0, testRegEn, singleSupply}, 8'h01);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr0();
    t_pins();
    t_w1c();
    t_pfail();
    t_roll();
    t_collide();
    t_osc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule